// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms the 20-bit physical memory address for a small real-mode processor bus interface. It holds four writable 16-bit segment bases: code, data, stack and extra. For each memory request it picks one of them. The choice depends on the kind of access, on whether the request's base register is the frame pointer (BP), and on an optional segment override. The chosen base is shifted left by four bit positions and added to the 16-bit effective offset. Any carry out of the top address bit is dropped, so the address space wraps at 1 MB.

The requester presents one request per cycle with `req_valid`. One clock later the block returns the physical address, a one-cycle valid strobe and a code naming the segment that was used. After reset the code base holds FFFFh. A fetch with instruction pointer 0000h therefore yields the start-up address FFFF0h. Many different base:offset pairs name the same byte, because bases are spaced 16 bytes apart.

Top module: `seg_phys_addr_gen`

## Requirements
- R1: The physical address equals (selected base × 16) + offset, taken over 20 bits.
- R2: A carry out of bit 19 is discarded. Base FFFFh with offset FFFFh gives 0FFEFh.
- R3: A request of kind 0 (instruction fetch) always uses the code base, whatever the override inputs hold.
- R4: With no override, a request of kind 2 (push/pop), or any request of kind 1 with `req_bp_base` high, uses the stack base.
- R5: A request of kind 3 (string destination) always uses the extra base, even when an override is valid.
- R6: With no override, a request of kind 1 with `req_bp_base` low uses the data base.
- R7: When `ovr_valid` is high, the base named by `ovr_sel` replaces the default for kinds 1 and 2.
- R8: After reset the code base is FFFFh and the data, stack and extra bases are 0000h. `addr_valid` and `phys_addr` are low.
- R9: A base write through `seg_wr_sel`/`seg_wr_data` is seen by requests in later cycles. A request in the same cycle as the write still uses the old value.
- R10: `addr_valid` rises exactly one cycle after each accepted request and lasts one cycle. `seg_used` reports the base used, coded extra=0, code=1, stack=2, data=3. The same coding applies to `seg_wr_sel` and `ovr_sel`.
- R11: The pairs 1234h:0010h, 1235h:0000h and 1200h:0350h all give 12350h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Write strobe for a segment base |
| seg_wr_sel | input | 2 | Base to write (extra=0, code=1, stack=2, data=3) |
| seg_wr_data | input | 16 | New base value |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | 0 fetch, 1 data, 2 push/pop, 3 string destination |
| req_bp_base | input | 1 | The effective address is based on BP |
| ovr_valid | input | 1 | A segment override applies |
| ovr_sel | input | 2 | Overriding base, same coding as seg_wr_sel |
| req_offset | input | 16 | Effective offset (IP for fetches) |
| addr_valid | output | 1 | One-cycle strobe: phys_addr and seg_used are valid |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Code of the base that formed phys_addr |

## Verification
Each result, address and segment code alike, is due one clock after the edge that samples the request. A base write is visible to requests sampled at the edge after the write edge. The bench drives inputs on the falling edge and checks outputs at the next falling edge, half a cycle after the rising edge that registers them. It then checks one more falling edge later that the strobe has dropped. For the write-timing case it drives a write and a request in the same cycle, and expects the old base first and the new base on the following request.

// File: rtl/seg_addr_pkg.sv
// Package: shared encodings for the segmented address generator.
// Assumes: two-bit codes for segment bases and access kinds, as listed in the brief.
package seg_addr_pkg;

    // Segment base identifiers; value order is part of the external interface
    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_id_t;

    // Kind of memory request
    typedef enum logic [1:0] {
        KIND_FETCH  = 2'd0,
        KIND_DATA   = 2'd1,
        KIND_STACK  = 2'd2,
        KIND_STRDST = 2'd3
    } req_kind_t;

    localparam int unsigned NUM_SEG = 4;
    localparam int unsigned SEG_IDX_W = $clog2(NUM_SEG);

endpackage

// File: rtl/seg_base_file.sv
// Module: seg_base_file
// Holds the writable segment bases. One write port; all bases readable in parallel.
// Assumes: synchronous active-low reset; the code base resets to CODE_RST, the rest to zero.
module seg_base_file
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W    = 16,
    parameter logic [15:0] CODE_RST = 16'hFFFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEG_IDX_W-1:0]          wr_sel,
    input  logic [SEG_W-1:0]              wr_data,
    output logic [NUM_SEG-1:0][SEG_W-1:0] bases
);

    logic [NUM_SEG-1:0][SEG_W-1:0] base_q;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_base
        localparam logic [SEG_W-1:0] RST_VAL =
            (g == int'(SEG_CODE)) ? SEG_W'(CODE_RST) : '0;

        // Purpose: reset or update one segment base
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= RST_VAL;
            end else if (wr_en && (wr_sel == SEG_IDX_W'(g))) begin
                base_q[g] <= wr_data;
            end
        end
    end

    assign bases = base_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> base_q[$past(wr_sel)] == $past(wr_data)); // R9

endmodule

// File: rtl/seg_chooser.sv
// Module: seg_chooser
// Picks which segment base serves a request, from kind, BP-base flag and override.
// Assumes: fetch and string-destination choices cannot be overridden.
module seg_chooser
    import seg_addr_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       bp_base,
    input  logic       ovr_valid,
    input  logic [1:0] ovr_sel,
    output logic [1:0] seg_sel
);

    req_kind_t kind_e;
    seg_id_t   dflt;
    seg_id_t   pick;

    assign kind_e = req_kind_t'(kind);

    // Purpose: default base implied by the access kind and base register
    always_comb begin
        unique case (kind_e)
            KIND_FETCH:  dflt = SEG_CODE;
            KIND_STACK:  dflt = SEG_STACK;
            KIND_STRDST: dflt = SEG_EXTRA;
            default:     dflt = bp_base ? SEG_STACK : SEG_DATA;
        endcase
    end

    // Purpose: apply an override where the access kind allows it
    always_comb begin
        pick = dflt;
        if (ovr_valid && (kind_e == KIND_DATA || kind_e == KIND_STACK)) begin
            pick = seg_id_t'(ovr_sel);
        end
    end

    assign seg_sel = pick;

endmodule

// File: rtl/phys_addr_stage.sv
// Module: phys_addr_stage
// Registers (base << SHIFT) + offset, truncated to ADDR_W bits, with valid and segment code.
// Assumes: SEG_W + SHIFT == ADDR_W; the carry out of the top bit is dropped.
module phys_addr_stage #(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned SHIFT  = 4,
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEG_W-1:0]  base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [1:0]        seg_code,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_code
);

    localparam int unsigned SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0]  base_ext;
    logic [SUM_W-1:0]  off_ext;
    logic [SUM_W-1:0]  sum_full;
    logic [ADDR_W-1:0] sum_wrapped;

    // Purpose: widen operands and add, keeping the carry bit visible
    always_comb begin
        base_ext    = SUM_W'({base, {SHIFT{1'b0}}});
        off_ext     = SUM_W'(offset);
        sum_full    = base_ext + off_ext;
        sum_wrapped = sum_full[ADDR_W-1:0];
    end

    // Purpose: register the result; address and code update only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= sum_wrapped;
                out_code <= seg_code;
            end
        end
    end

    AST_LOW_NIBBLE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr[SHIFT-1:0] == $past(offset[SHIFT-1:0])); // R1

endmodule

// File: rtl/seg_phys_addr_gen.sv
// Module: seg_phys_addr_gen (top)
// Segmented physical address generator: base file, base chooser and registered adder.
// Assumes: one request per cycle; results appear one cycle later; active-low sync reset.
module seg_phys_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W    = 16,
    parameter int unsigned OFF_W    = 16,
    parameter int unsigned SHIFT    = 4,
    parameter int unsigned ADDR_W   = SEG_W + SHIFT,
    parameter logic [15:0] CODE_RST = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [1:0]        seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_bp_base,
    input  logic              ovr_valid,
    input  logic [1:0]        ovr_sel,
    input  logic [OFF_W-1:0]  req_offset,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [1:0]        seg_used
);

    logic [NUM_SEG-1:0][SEG_W-1:0] bases;
    logic [1:0]                    sel_code;
    logic [SEG_W-1:0]              sel_base;

    seg_base_file #(
        .SEG_W    (SEG_W),
        .CODE_RST (CODE_RST)
    ) u_bases (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .bases   (bases)
    );

    seg_chooser u_chooser (
        .kind      (req_kind),
        .bp_base   (req_bp_base),
        .ovr_valid (ovr_valid),
        .ovr_sel   (ovr_sel),
        .seg_sel   (sel_code)
    );

    // Purpose: read the chosen base (pre-write value when a write shares the cycle)
    assign sel_base = bases[sel_code];

    phys_addr_stage #(
        .SEG_W  (SEG_W),
        .OFF_W  (OFF_W),
        .SHIFT  (SHIFT),
        .ADDR_W (ADDR_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .base      (sel_base),
        .offset    (req_offset),
        .seg_code  (sel_code),
        .out_valid (addr_valid),
        .out_addr  (phys_addr),
        .out_code  (seg_used)
    );

    AST_STROBE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid); // R10

    AST_NO_STROBE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid); // R10

    AST_FETCH_USES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |=> seg_used == 2'd1); // R3

    AST_STRDST_USES_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> seg_used == 2'd0); // R5

    AST_OVERRIDE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_valid && req_kind[1] != req_kind[0]) |=> seg_used == $past(ovr_sel)); // R7

endmodule

// File: tb/test_seg_phys_addr_gen.sv
`timescale 1ns/1ps
module test_seg_phys_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        req_bp_base;
    logic        ovr_valid;
    logic [1:0]  ovr_sel;
    logic [15:0] req_offset;
    logic        addr_valid;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] model [4];

    localparam logic [1:0] S_ES = 2'd0, S_CS = 2'd1, S_SS = 2'd2, S_DS = 2'd3;
    localparam logic [1:0] K_FETCH = 2'd0, K_DATA = 2'd1, K_STACK = 2'd2, K_STR = 2'd3;

    always #4 clk = ~clk;

    seg_phys_addr_gen i_seg_phys_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_bp_base(req_bp_base),
        .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .req_offset(req_offset),
        .addr_valid(addr_valid), .phys_addr(phys_addr), .seg_used(seg_used)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] expect_addr(input logic [15:0] b, input logic [15:0] o);
        logic [20:0] s;
        s = {1'b0, b, 4'h0} + {5'h0, o};
        return s[19:0];
    endfunction

    task automatic wr_seg(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = d;
        @(negedge clk);
        seg_wr_en = 1'b0;
        model[sel] = d;
    endtask

    // Present one request; on return the result is on the outputs
    task automatic issue(input logic [1:0] k, input logic bp, input logic ov,
                         input logic [1:0] os, input logic [15:0] off);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_bp_base = bp;
        ovr_valid = ov; ovr_sel = os; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0; ovr_valid = 1'b0; req_bp_base = 1'b0;
    endtask

    task automatic expect_result(input string tag, input logic [1:0] seg, input logic [15:0] off);
        check({tag, " valid"}, 32'(addr_valid), 32'd1);
        check({tag, " addr"},  32'(phys_addr),  32'(expect_addr(model[seg], off)));
        check({tag, " seg"},   32'(seg_used),   32'(seg));
    endtask

    task automatic t_reset_state();
        check("R8 valid after reset", 32'(addr_valid), 32'd0);
        check("R8 addr after reset",  32'(phys_addr),  32'd0);
        issue(K_DATA, 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R8 data base zero", 32'(phys_addr), 32'h00000);
        issue(K_STACK, 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R8 stack base zero", 32'(phys_addr), 32'h00000);
        issue(K_STR, 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R8 extra base zero", 32'(phys_addr), 32'h00000);
    endtask

    task automatic t_boot_fetch();
        issue(K_FETCH, 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R8 boot fetch addr", 32'(phys_addr), 32'hFFFF0);
        check("R3 boot fetch seg",  32'(seg_used),  32'(S_CS));
        @(negedge clk);
        check("R10 strobe one cycle", 32'(addr_valid), 32'd0);
    endtask

    task automatic t_alias();
        wr_seg(S_DS, 16'h1234);
        issue(K_DATA, 1'b0, 1'b0, 2'd0, 16'h0010);
        check("R11 1234:0010", 32'(phys_addr), 32'h12350);
        wr_seg(S_DS, 16'h1235);
        issue(K_DATA, 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R11 1235:0000", 32'(phys_addr), 32'h12350);
        wr_seg(S_DS, 16'h1200);
        issue(K_DATA, 1'b0, 1'b0, 2'd0, 16'h0350);
        check("R11 1200:0350", 32'(phys_addr), 32'h12350);
    endtask

    task automatic t_formula_and_wrap();
        wr_seg(S_SS, 16'hABCD);
        issue(K_STACK, 1'b0, 1'b0, 2'd0, 16'h8FFF);
        expect_result("R1 carry into high bits", S_SS, 16'h8FFF);
        wr_seg(S_DS, 16'hFFFF);
        issue(K_DATA, 1'b0, 1'b0, 2'd0, 16'hFFFF);
        check("R2 wrap FFFF:FFFF", 32'(phys_addr), 32'h0FFEF);
        wr_seg(S_ES, 16'hF800);
        issue(K_STR, 1'b0, 1'b0, 2'd0, 16'h8010);
        check("R2 wrap F800:8010", 32'(phys_addr), 32'h00010);
    endtask

    task automatic t_defaults();
        wr_seg(S_CS, 16'h2000);
        wr_seg(S_DS, 16'h3000);
        wr_seg(S_SS, 16'h4000);
        wr_seg(S_ES, 16'h5000);
        issue(K_FETCH, 1'b1, 1'b0, 2'd0, 16'h0123);
        expect_result("R3 fetch", S_CS, 16'h0123);
        issue(K_STACK, 1'b0, 1'b0, 2'd0, 16'hFFFE);
        expect_result("R4 push/pop", S_SS, 16'hFFFE);
        issue(K_DATA, 1'b1, 1'b0, 2'd0, 16'h0040);
        expect_result("R4 BP based", S_SS, 16'h0040);
        issue(K_DATA, 1'b0, 1'b0, 2'd0, 16'h0777);
        expect_result("R6 plain data", S_DS, 16'h0777);
        issue(K_STR, 1'b0, 1'b0, 2'd0, 16'h0100);
        expect_result("R5 string dest", S_ES, 16'h0100);
    endtask

    task automatic t_override();
        issue(K_DATA, 1'b0, 1'b1, S_ES, 16'h0020);
        expect_result("R7 data to extra", S_ES, 16'h0020);
        issue(K_DATA, 1'b1, 1'b1, S_DS, 16'h0030);
        expect_result("R7 BP to data", S_DS, 16'h0030);
        issue(K_STACK, 1'b0, 1'b1, S_CS, 16'h0044);
        expect_result("R7 stack to code", S_CS, 16'h0044);
        issue(K_FETCH, 1'b0, 1'b1, S_DS, 16'h0050);
        expect_result("R3 fetch ignores override", S_CS, 16'h0050);
        issue(K_STR, 1'b0, 1'b1, S_SS, 16'h0060);
        expect_result("R5 string dest ignores override", S_ES, 16'h0060);
    endtask

    task automatic t_write_timing();
        wr_seg(S_DS, 16'h1200);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = S_DS; seg_wr_data = 16'h5000;
        req_valid = 1'b1; req_kind = K_DATA; req_bp_base = 1'b0;
        ovr_valid = 1'b0; req_offset = 16'h0000;
        @(negedge clk);
        seg_wr_en = 1'b0;
        check("R9 same-cycle uses old base", 32'(phys_addr), 32'h12000);
        check("R10 back-to-back valid", 32'(addr_valid), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        model[S_DS] = 16'h5000;
        check("R9 next request uses new base", 32'(phys_addr), 32'h50000);
        @(negedge clk);
        check("R10 strobe drops", 32'(addr_valid), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = 2'd0; seg_wr_data = 16'h0;
        req_valid = 1'b0; req_kind = 2'd0; req_bp_base = 1'b0;
        ovr_valid = 1'b0; ovr_sel = 2'd0; req_offset = 16'h0;
        model[S_ES] = 16'h0000; model[S_CS] = 16'hFFFF;
        model[S_SS] = 16'h0000; model[S_DS] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_boot_fetch();
        t_alias();
        t_formula_and_wrap();
        t_defaults();
        t_override();
        t_write_timing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule